// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the bus-side state machine of a small processor whose low address bits and data bits leave the chip on the same pins, and whose top address bits share pins with status bits. A core hands it one transfer at a time: an address, write data, a direction, a memory-or-I/O flag, an upper-byte enable, the segment in use and the interrupt-enable flag. The block runs that transfer as a bus cycle of at least four clock states. In the first state it puts the address on the shared pins and pulses the latch strobe so that external logic can capture the address. In the states after that it moves data and shows status on the upper pins.

The ready input stretches a cycle with wait states. A hold request floats the bus between cycles and is acknowledged on a dedicated output. The core holds its request until it sees the single-cycle completion pulse. For reads, the returned data is presented together with that pulse.

Top module: `mux_bus_ctrl`

## Requirements
- R1: With ready high, an accepted request produces exactly four bus states. T1 follows the accepting clock edge, then T2, T3 and T4. The read strobe (rd_n, active low) or the write strobe (wr_n, active low) is low in T2 and T3 only, never both, and is high in T1 and T4.
- R2: In T1, and only in T1, ale is 1. ad_out carries address bits [15:0] with ad_oe=1, as_out carries address bits [19:16], and bhe_n equals the inverse of the upper-byte request.
- R3: Ready is sampled at the end of T3 and at the end of every wait state. Each low sample inserts one wait state, during which the active strobe stays low. T4 follows the first high sample.
- R4: dt_r is 1 for a write and 0 for a read from T1 through T4. For a write, ad_out carries the write data with ad_oe=1 in T2, T3, any wait states and T4. For a read, ad_oe is 0 in those states.
- R5: den_n (active low) is 0 in T2, T3, wait states and T4, and 1 in T1 and when no cycle is running.
- R6: io_m is 0 for a memory transfer and 1 for an I/O transfer, throughout T1 to T4.
- R7: From T2 through T4, as_out shows status: bits [1:0] hold the segment code, bit 2 holds the interrupt-enable flag and bit 3 is 0. The bhe_n pin shows a constant 1 in those states.
- R8: Hold sampled high while no cycle runs makes hlda 1 and bus_oe 0 (with ad_oe 0) from the next clock. A request present during hold does not start a cycle (ale stays 0) until hold is released.
- R9: Hold raised in the middle of a cycle is not honoured until that cycle has finished, so hlda stays 0 through T4 and the completion cycle. hlda falls one clock after hold is sampled low.
- R10: done is a one-cycle pulse in the clock after T4. For a read, rdata equals the value of ad_in in T4. rdata keeps its value across writes.
- R11: During and right after reset, no cycle runs: ale=0, rd_n=wr_n=den_n=1, hlda=0, done=0, bus_oe=1, ad_oe=0.
- R12: A request still present in the cycle carrying done is not started. If it is still present one clock later, it starts, with T1 in the second clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core transfer request, held until done |
| req_addr | input | AW (20) | Transfer address |
| req_wdata | input | DW (16) | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_bhe | input | 1 | Upper data byte takes part in the transfer |
| req_seg | input | SEGW (2) | Segment code shown as status |
| req_ie | input | 1 | Interrupt-enable flag shown as status |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Data captured by the last read |
| ad_out | output | DW (16) | Shared address/data pins, outgoing value |
| ad_in | input | DW (16) | Shared address/data pins, incoming value |
| ad_oe | output | 1 | Drive enable for the shared address/data pins |
| as_out | output | AW-DW (4) | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Upper-byte enable (low active) in T1, status 1 afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| io_m | output | 1 | 1 = I/O address, 0 = memory address |
| bus_oe | output | 1 | Drive enable for address, status and control pins |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | Bus hold request |
| hlda | output | 1 | Hold acknowledge |

## Verification
A wrong state in the sequencer shows up at the pins within one clock. A skipped or repeated phase moves ale, the strobes or den_n off the positions fixed above, and the bench checks every one of these signals in every phase. A wrong wait-state count changes how long a strobe stays low, and a hold taken in the middle of a cycle raises hlda while a strobe is still active. Errors in the captured request (direction, space, segment or flag) appear in T1 or T2 on dt_r, io_m and as_out. A wrong read capture appears on rdata when done pulses.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;

    // Bus phases; TW is a wait state, HOLD means the bus is floated for another master
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

    // Single-bit control pins produced by the pin decoder
    typedef struct packed {
        logic ale;
        logic rd_n;
        logic wr_n;
        logic den_n;
        logic dt_r;
        logic io_m;
        logic bhe_n;
        logic bus_oe;
        logic ad_oe;
        logic hlda;
    } ctl_pins_t;

endpackage

// File: rtl/mbc_fsm.sv
`timescale 1ns/1ps
module mbc_fsm
    import mbc_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int SEGW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_bhe,
    input  logic [SEGW-1:0]   req_seg,
    input  logic              req_ie,
    input  logic              ready,
    input  logic              hold,
    input  logic [DW-1:0]     ad_in,
    output bus_state_e        state,
    output logic [AW-1:0]     cur_addr,
    output logic [DW-1:0]     cur_wdata,
    output logic              cur_write,
    output logic              cur_io,
    output logic              cur_bhe,
    output logic [SEGW-1:0]   cur_seg,
    output logic              cur_ie,
    output logic              done,
    output logic [DW-1:0]     rdata
);

    typedef struct packed {
        bus_state_e          st;
        logic [AW-1:0]       addr;
        logic [DW-1:0]       wdata;
        logic                write;
        logic                io;
        logic                bhe;
        logic [SEGW-1:0]     seg;
        logic                ie;
        logic                done;
        logic [DW-1:0]       rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                // hold wins over a pending request; a request seen with done is the old one
                if (hold) begin
                    r_d.st = ST_HOLD;
                end else if (req_valid && !r_q.done) begin
                    r_d.st    = ST_T1;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.write = req_write;
                    r_d.io    = req_io;
                    r_d.bhe   = req_bhe;
                    r_d.seg   = req_seg;
                    r_d.ie    = req_ie;
                end
            end
            ST_T1:   r_d.st = ST_T2;
            ST_T2:   r_d.st = ST_T3;
            ST_T3:   r_d.st = ready ? ST_T4 : ST_TW;
            ST_TW:   r_d.st = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (!r_q.write) begin
                    r_d.rdata = ad_in;
                end
            end
            ST_HOLD: begin
                if (!hold) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign cur_addr  = r_q.addr;
    assign cur_wdata = r_q.wdata;
    assign cur_write = r_q.write;
    assign cur_io    = r_q.io;
    assign cur_bhe   = r_q.bhe;
    assign cur_seg   = r_q.seg;
    assign cur_ie    = r_q.ie;
    assign done      = r_q.done;
    assign rdata     = r_q.rdata;

endmodule

// File: rtl/mbc_pinmux.sv
`timescale 1ns/1ps
module mbc_pinmux
    import mbc_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int SEGW = 2
) (
    input  bus_state_e        state,
    input  logic [AW-1:0]     cur_addr,
    input  logic [DW-1:0]     cur_wdata,
    input  logic              cur_write,
    input  logic              cur_io,
    input  logic              cur_bhe,
    input  logic [SEGW-1:0]   cur_seg,
    input  logic              cur_ie,
    output logic [DW-1:0]     ad_out,
    output logic [AW-DW-1:0]  as_out,
    output ctl_pins_t         ctl
);

    localparam int UW = AW - DW;

    logic [UW-1:0] stat_w;

    // status word: segment code at the bottom, then the interrupt flag, zeros above
    for (genvar g = 0; g < UW; g++) begin : g_stat
        if (g < SEGW) begin : g_seg
            assign stat_w[g] = cur_seg[g];
        end else if (g == SEGW) begin : g_ie
            assign stat_w[g] = cur_ie;
        end else begin : g_zero
            assign stat_w[g] = 1'b0;
        end
    end

    logic data_phase;
    assign data_phase = (state == ST_T2) || (state == ST_T3) ||
                        (state == ST_TW) || (state == ST_T4);

    always_comb begin
        ctl        = '0;
        ctl.rd_n   = 1'b1;
        ctl.wr_n   = 1'b1;
        ctl.den_n  = 1'b1;
        ctl.bhe_n  = 1'b1;
        ctl.bus_oe = 1'b1;
        ad_out     = '0;
        as_out     = '0;

        if (state == ST_T1) begin
            ctl.ale   = 1'b1;
            ctl.ad_oe = 1'b1;
            ctl.bhe_n = !cur_bhe;
            ctl.dt_r  = cur_write;
            ctl.io_m  = cur_io;
            ad_out    = cur_addr[DW-1:0];
            as_out    = cur_addr[AW-1:DW];
        end

        if (data_phase) begin
            ctl.den_n = 1'b0;
            ctl.dt_r  = cur_write;
            ctl.io_m  = cur_io;
            as_out    = stat_w;
            if (cur_write) begin
                ctl.ad_oe = 1'b1;
                ad_out    = cur_wdata;
            end
            if (state != ST_T4) begin
                ctl.rd_n = cur_write;
                ctl.wr_n = !cur_write;
            end
        end

        if (state == ST_HOLD) begin
            ctl.bus_oe = 1'b0;
            ctl.hlda   = 1'b1;
        end
    end

endmodule

// File: rtl/mux_bus_ctrl.sv
`timescale 1ns/1ps
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int SEGW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_bhe,
    input  logic [SEGW-1:0]   req_seg,
    input  logic              req_ie,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     ad_out,
    input  logic [DW-1:0]     ad_in,
    output logic              ad_oe,
    output logic [AW-DW-1:0]  as_out,
    output logic              bhe_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r,
    output logic              io_m,
    output logic              bus_oe,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda
);

    bus_state_e          state;
    logic [AW-1:0]       cur_addr;
    logic [DW-1:0]       cur_wdata;
    logic                cur_write;
    logic                cur_io;
    logic                cur_bhe;
    logic [SEGW-1:0]     cur_seg;
    logic                cur_ie;
    ctl_pins_t           ctl;

    mbc_fsm #(.AW(AW), .DW(DW), .SEGW(SEGW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .req_bhe   (req_bhe),
        .req_seg   (req_seg),
        .req_ie    (req_ie),
        .ready     (ready),
        .hold      (hold),
        .ad_in     (ad_in),
        .state     (state),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .cur_bhe   (cur_bhe),
        .cur_seg   (cur_seg),
        .cur_ie    (cur_ie),
        .done      (done),
        .rdata     (rdata)
    );

    mbc_pinmux #(.AW(AW), .DW(DW), .SEGW(SEGW)) u_pins (
        .state     (state),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .cur_bhe   (cur_bhe),
        .cur_seg   (cur_seg),
        .cur_ie    (cur_ie),
        .ad_out    (ad_out),
        .as_out    (as_out),
        .ctl       (ctl)
    );

    assign ale    = ctl.ale;
    assign rd_n   = ctl.rd_n;
    assign wr_n   = ctl.wr_n;
    assign den_n  = ctl.den_n;
    assign dt_r   = ctl.dt_r;
    assign io_m   = ctl.io_m;
    assign bhe_n  = ctl.bhe_n;
    assign bus_oe = ctl.bus_oe;
    assign ad_oe  = ctl.ad_oe;
    assign hlda   = ctl.hlda;

endmodule

// File: rtl/mbc_checker.sv
`timescale 1ns/1ps
module mbc_checker (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dt_r,
    input logic ad_oe,
    input logic bus_oe,
    input logic hlda,
    input logic hold,
    input logic ready,
    input logic done
);

    AST_ALE_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && den_n && ad_oe)); // R2

    AST_ALE_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && !den_n)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R1

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_n && wr_n) && !ready) |=> !(rd_n && wr_n)); // R3

    AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (dt_r && ad_oe)); // R4

    AST_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!dt_r && !ad_oe)); // R4

    AST_DEN_NOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n |-> !ale); // R5

    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !ad_oe && !ale)); // R8

    AST_NO_HOLD_MID_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |=> !hlda); // R9

    AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> !hlda); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

bind mux_bus_ctrl mbc_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .dt_r   (dt_r),
    .ad_oe  (ad_oe),
    .bus_oe (bus_oe),
    .hlda   (hlda),
    .hold   (hold),
    .ready  (ready),
    .done   (done)
);

// File: tb/mux_bus_ctrl_test.sv
`timescale 1ns/1ps
module mux_bus_ctrl_test;

    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int SEGW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_write = 1'b0;
    logic            req_io = 1'b0;
    logic            req_bhe = 1'b0;
    logic [SEGW-1:0] req_seg = '0;
    logic            req_ie = 1'b0;
    logic            done;
    logic [DW-1:0]   rdata;
    logic [DW-1:0]   ad_out;
    logic [DW-1:0]   ad_in = '0;
    logic            ad_oe;
    logic [AW-DW-1:0] as_out;
    logic            bhe_n, ale, rd_n, wr_n, den_n, dt_r, io_m, bus_oe, hlda;
    logic            ready = 1'b1;
    logic            hold = 1'b0;

    int vectors = 0;
    int fails   = 0;
    logic [DW-1:0] last_rd = '0;

    always #2.5 clk = ~clk;

    mux_bus_ctrl #(.AW(AW), .DW(DW), .SEGW(SEGW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .req_bhe(req_bhe), .req_seg(req_seg), .req_ie(req_ie), .done(done),
        .rdata(rdata), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
        .as_out(as_out), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .dt_r(dt_r), .io_m(io_m), .bus_oe(bus_oe),
        .ready(ready), .hold(hold), .hlda(hlda)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_pins(input string tag);
        chk({tag, " ale"}, ale, 1'b0);
        chk({tag, " rd_n"}, rd_n, 1'b1);
        chk({tag, " wr_n"}, wr_n, 1'b1);
        chk({tag, " den_n"}, den_n, 1'b1);
        chk({tag, " hlda"}, hlda, 1'b0);
        chk({tag, " done"}, done, 1'b0);
        chk({tag, " bus_oe"}, bus_oe, 1'b1);
        chk({tag, " ad_oe"}, ad_oe, 1'b0);
    endtask

    // Runs one transfer and checks every phase of it
    task automatic run_xfer(input logic wr, input logic io, input logic bhe,
                            input logic [1:0] seg, input logic ie,
                            input logic [19:0] addr, input logic [15:0] wd,
                            input logic [15:0] rv, input int nwait, input logic hold_mid);
        logic [3:0] stat;
        stat = {1'b0, ie, seg};
        req_valid = 1'b1; req_write = wr; req_io = io; req_bhe = bhe;
        req_seg = seg; req_ie = ie; req_addr = addr; req_wdata = wd;
        ready = (nwait == 0); ad_in = rv;
        step(); // T1
        chk("R2 ale in T1", ale, 1'b1);
        chk("R2 low address", ad_out, addr[15:0]);
        chk("R2 ad_oe in T1", ad_oe, 1'b1);
        chk("R2 upper address", as_out, addr[19:16]);
        chk("R2 bhe_n", bhe_n, !bhe);
        chk("R1 strobes idle in T1", {rd_n, wr_n}, 2'b11);
        chk("R5 den_n in T1", den_n, 1'b1);
        chk("R4 dt_r in T1", dt_r, wr);
        chk("R6 io_m in T1", io_m, io);
        if (hold_mid) hold = 1'b1;
        step(); // T2
        chk("R1 ale low in T2", ale, 1'b0);
        chk("R1 rd_n in T2", rd_n, wr);
        chk("R1 wr_n in T2", wr_n, !wr);
        chk("R5 den_n in T2", den_n, 1'b0);
        chk("R7 status", as_out, stat);
        chk("R7 status bit on bhe pin", bhe_n, 1'b1);
        chk("R4 ad_oe in T2", ad_oe, wr);
        if (wr) chk("R4 write data", ad_out, wd);
        chk("R6 io_m in T2", io_m, io);
        chk("R9 no hlda mid cycle", hlda, 1'b0);
        step(); // T3
        chk("R1 rd_n in T3", rd_n, wr);
        chk("R1 wr_n in T3", wr_n, !wr);
        chk("R4 dt_r in T3", dt_r, wr);
        for (int w = 0; w < nwait; w++) begin
            step(); // wait state
            chk("R3 strobe held in wait", {rd_n, wr_n}, {wr, !wr});
            chk("R5 den_n in wait", den_n, 1'b0);
            chk("R3 no done in wait", done, 1'b0);
            chk("R9 no hlda in wait", hlda, 1'b0);
            if (w == nwait - 1) ready = 1'b1;
        end
        step(); // T4
        chk("R1 strobes released in T4", {rd_n, wr_n}, 2'b11);
        chk("R5 den_n in T4", den_n, 1'b0);
        chk("R4 dt_r in T4", dt_r, wr);
        chk("R10 no done in T4", done, 1'b0);
        chk("R9 no hlda in T4", hlda, 1'b0);
        step(); // completion cycle
        chk("R10 done pulse", done, 1'b1);
        if (!wr) last_rd = rv;
        chk("R10 rdata", rdata, last_rd);
        chk("R9 hold deferred past cycle", hlda, 1'b0);
        chk("R1 no new ale", ale, 1'b0);
        req_valid = 1'b0;
        step();
        chk("R10 done single cycle", done, 1'b0);
        if (hold_mid) begin
            chk("R9 hlda after cycle", hlda, 1'b1);
            chk("R9 bus floated", bus_oe, 1'b0);
            hold = 1'b0;
            step();
            chk("R9 hlda released", hlda, 1'b0);
            chk("R9 bus driven again", bus_oe, 1'b1);
        end
        ready = 1'b1;
    endtask

    task automatic test_reset();
        idle_pins("R11 in reset");
        rst_n = 1'b1;
        step();
        idle_pins("R11 after reset");
    endtask

    task automatic test_read_mem();
        run_xfer(1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 20'hA5C3E, 16'h0000, 16'hBEEF, 0, 1'b0);
    endtask

    task automatic test_write_io();
        run_xfer(1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 20'h31234, 16'h55AA, 16'h1111, 0, 1'b0);
    endtask

    task automatic test_wait_states();
        run_xfer(1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 20'hF00F0, 16'h0000, 16'h2468, 2, 1'b0);
        run_xfer(1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 20'h0ABCD, 16'hC3C3, 16'h0000, 1, 1'b0);
    endtask

    task automatic test_hold_idle();
        hold = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0; req_bhe = 1'b1;
        req_seg = 2'b10; req_ie = 1'b0; req_addr = 20'h7E001; ad_in = 16'h9A9A;
        step();
        chk("R8 hlda", hlda, 1'b1);
        chk("R8 bus_oe", bus_oe, 1'b0);
        chk("R8 ad_oe", ad_oe, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 request postponed", ale, 1'b0);
            chk("R8 hlda kept", hlda, 1'b1);
        end
        hold = 1'b0;
        step();
        chk("R9 hlda drops one clock after hold", hlda, 1'b0);
        chk("R8 no ale yet", ale, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 20'h7E001, 16'h0000, 16'h9A9A, 0, 1'b0);
    endtask

    task automatic test_hold_mid();
        run_xfer(1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 20'h12345, 16'h7777, 16'h0000, 1, 1'b1);
    endtask

    task automatic test_back_to_back();
        req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0; req_bhe = 1'b0;
        req_seg = 2'b00; req_ie = 1'b0; req_addr = 20'h00400; ad_in = 16'h0506;
        ready = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk("R12 done seen", done, 1'b1);
        chk("R12 rdata", rdata, 16'h0506);
        last_rd = 16'h0506;
        step();
        chk("R12 no restart in done cycle", ale, 1'b0);
        step();
        chk("R12 request accepted afterwards", ale, 1'b1);
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) step();
        chk("R12 second transfer finished", done, 1'b0);
        idle_pins("R11 idle after back-to-back");
    endtask

    initial begin
        #500_000;
        vectors++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_read_mem();
        test_write_io();
        test_wait_states();
        test_hold_idle();
        test_hold_mid();
        test_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule